// File: doc/BRIEF.md
# I2C Slave Transmit Byte Path

This block queues the bytes a device returns when it answers an I2C read as a slave. Software or a DMA engine writes bytes over a valid/ready write port into a 16-entry FIFO. A read-only level output gives the number of bytes not yet sent. The bus engine, seen here only as three strobes, pulls the bytes out one bit at a time. The strobes are: session start, bit request and byte complete.

Back-pressure on the write port works as follows. `wr_ready` is high whenever the FIFO holds fewer than 16 bytes. A byte is taken in any cycle where both `wr_valid` and `wr_ready` are high. If `wr_valid` is raised while `wr_ready` is low, the byte is discarded rather than held, and a sticky overflow flag is set. A writer that honours `wr_ready` never loses data.

Each bit request places the next bit of the head byte on `sda_out`, starting with the most significant bit. The head byte leaves the FIFO only when the byte-complete strobe arrives. A 7-bit counter of sent bytes restarts at every session start and wraps.

Top module: `i2c_stx_path`

## Requirements
- R1: When `wr_valid` and `wr_ready` are both high at a clock edge, `wr_data` is stored at the tail of the FIFO and `level` rises by one after that edge, unless a byte leaves in the same cycle (see R6).
- R2: `level` is 5 bits wide and counts the unsent bytes. `full` is 1 exactly when `level` is 16 and `empty` is 1 exactly when `level` is 0. `wr_ready` is the inverse of `full`.
- R3: A write with `wr_valid` high while `full` is 1 is discarded: `level` and the FIFO contents are unchanged. `overflow` goes to 1 on the next cycle and stays at 1 until reset.
- R4: Each `bit_req` pulse while the FIFO holds data drives the next bit of the head byte onto `sda_out` in the following cycle. Bit 7 goes first and bit 0 goes eighth.
- R5: `bit_req` never removes a byte. A byte is removed and `level` drops by one only on `byte_done` while the FIFO is not empty. The next bit request then starts at bit 7 of the new head byte.
- R6: If a write is accepted in the same cycle as a `byte_done` removal, `level` does not change, and the new byte is kept behind the bytes already queued.
- R7: A `bit_req` while the FIFO is empty drives `sda_out` to 1 and sets `underrun`. `underrun` stays at 1 until the next `sess_start`.
- R8: `sent_cnt` is 7 bits wide and rises by one on each `byte_done` that removes a byte. It wraps from 127 to 0. A `byte_done` with an empty FIFO leaves it unchanged.
- R9: `sess_start` clears `sent_cnt` to 0 and restarts the bit position at bit 7. It also clears `underrun`. When `sess_start` and a removing `byte_done` fall in the same cycle, the byte is still removed but `sent_cnt` ends at 0.
- R10: After reset, `level` is 0, `empty` is 1, `full` is 0, `sent_cnt` is 0, `sda_out` is 1, and both `overflow` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | A byte is offered on the write port |
| wr_ready | output | 1 | FIFO can take a byte (not full) |
| wr_data | input | 8 | Byte to queue |
| sess_start | input | 1 | Strobe: a transmit session begins |
| bit_req | input | 1 | Strobe: the bus engine wants the next bit |
| byte_done | input | 1 | Strobe: the current byte has been fully sent |
| sda_out | output | 1 | Serial data bit toward the bus engine |
| level | output | 5 | Number of unsent bytes in the FIFO |
| full | output | 1 | FIFO holds 16 bytes |
| empty | output | 1 | FIFO holds no bytes |
| sent_cnt | output | 7 | Bytes sent in this session, wrapping |
| overflow | output | 1 | Sticky: a write was discarded because the FIFO was full |
| underrun | output | 1 | Sticky: a bit was requested while the FIFO was empty |

## Verification
The write port and the byte-complete removal can land on the same edge. In that cycle the FIFO must keep its level while it moves both pointers. The bench provokes this by raising `wr_valid` together with the `byte_done` that closes a byte. It then checks that `level` is unchanged and that the next byte shifted out is the one just written. A second collision pairs `sess_start` with a removing `byte_done`. There, `sent_cnt` must read 0 while `level` still falls by one.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
  localparam int unsigned STX_DATA_W = 8;
  localparam int unsigned STX_DEPTH  = 16;
  localparam int unsigned STX_CNT_W  = 7;
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] CAP      = LVL_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [LVL_W-1:0]  fill_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  assign head  = store[rd_ptr];
  assign level = fill_q;
  assign full  = (fill_q == CAP);
  assign empty = (fill_q == '0);

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> level == LVL_W'($past(level) + 1'b1));

  // R6
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> level == $past(level));

  // R2
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_start,
  input  logic              bit_req,
  input  logic              byte_done,
  input  logic              have_data,
  input  logic [DATA_W-1:0] head,
  output logic              sda,
  output logic              underrun
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] sel;
  logic             sda_q, und_q;

  assign sel = IDX_W'(DATA_W - 1) - idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      sda_q <= 1'b1;
      und_q <= 1'b0;
    end else begin
      if (bit_req) begin
        if (have_data) begin
          sda_q <= head[sel];
          idx_q <= idx_q + 1'b1;
        end else begin
          sda_q <= 1'b1;
          und_q <= 1'b1;
        end
      end
      if (byte_done || sess_start) idx_q <= '0;
      if (sess_start) und_q <= 1'b0;
    end
  end

  assign sda      = sda_q;
  assign underrun = und_q;

  // R7
  starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !have_data && !sess_start) |=> (sda && underrun));

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && have_data && idx_q == '0) |=> sda == $past(head[DATA_W-1]));
endmodule

// File: rtl/stx_sent_counter.sv
module stx_sent_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (inc)   cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0);

  // R8
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |=> count == CNT_W'($past(count) + 1'b1));
endmodule

// File: rtl/i2c_stx_path.sv
module i2c_stx_path
  import i2c_stx_pkg::*;
#(
  parameter int unsigned DATA_W = STX_DATA_W,
  parameter int unsigned DEPTH  = STX_DEPTH,
  parameter int unsigned CNT_W  = STX_CNT_W,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sess_start,
  input  logic              bit_req,
  input  logic              byte_done,
  output logic              sda_out,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  sent_cnt,
  output logic              overflow,
  output logic              underrun
);
  logic              do_push, do_pop;
  logic [DATA_W-1:0] head_byte;
  logic              ovf_q;

  assign wr_ready = !full;
  assign do_push  = wr_valid && !full;
  assign do_pop   = byte_done && !empty;

  stx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .din(wr_data), .head(head_byte), .level(level),
    .full(full), .empty(empty)
  );

  stx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start),
    .bit_req(bit_req), .byte_done(byte_done), .have_data(!empty),
    .head(head_byte), .sda(sda_out), .underrun(underrun)
  );

  stx_sent_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(sess_start), .inc(do_pop),
    .count(sent_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovf_q <= 1'b0;
    else if (wr_valid && full) ovf_q <= 1'b1;
  end
  assign overflow = ovf_q;

  // R3
  drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !byte_done) |=> (level == $past(level) && overflow));

  // R3
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R5
  bit_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !byte_done && !wr_valid) |=> level == $past(level));
endmodule

// File: tb/tb_i2c_stx_path.sv
module tb_i2c_stx_path;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       sess_start = 1'b0;
  logic       bit_req = 1'b0;
  logic       byte_done = 1'b0;
  logic       sda_out;
  logic [4:0] level;
  logic       full, empty;
  logic [6:0] sent_cnt;
  logic       overflow, underrun;

  int total = 0;
  int bad = 0;
  int exp_lvl = 0;
  int exp_cnt = 0;
  logic [7:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stx_path dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .sess_start(sess_start), .bit_req(bit_req),
    .byte_done(byte_done), .sda_out(sda_out), .level(level), .full(full),
    .empty(empty), .sent_cnt(sent_cnt), .overflow(overflow),
    .underrun(underrun)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: offers one byte and records it when the model says it fits
  task automatic drive_byte(input logic [7:0] b);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
    if (exp_lvl < 16) begin
      sb_q.push_back(b);
      exp_lvl++;
    end
  endtask

  // monitor: collects 8 bits, closes the byte, compares with the scoreboard
  task automatic drain_byte(input bit chk_detail);
    logic [7:0] got;
    logic [7:0] want;
    for (int i = 0; i < 8; i++) begin
      bit_req = 1'b1;
      @(negedge clk);
      bit_req = 1'b0;
      got[7-i] = sda_out;
    end
    if (chk_detail) check("R5 level after bit requests", level, exp_lvl);
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
    want = sb_q.pop_front();
    exp_lvl--;
    exp_cnt = (exp_cnt + 1) % 128;
    check("R4 byte shifted MSB first", got, want);
    if (chk_detail) begin
      check("R5 level after byte_done", level, exp_lvl);
      check("R8 sent count", sent_cnt, exp_cnt);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 level", level, 0);
    check("R10 empty", empty, 1);
    check("R10 full", full, 0);
    check("R10 count", sent_cnt, 0);
    check("R10 sda", sda_out, 1);
    check("R10 overflow", overflow, 0);
    check("R10 underrun", underrun, 0);

    // R1, R2 basic queueing
    drive_byte(8'hA5);
    drive_byte(8'h3C);
    drive_byte(8'h80);
    check("R1 level after 3 writes", level, 3);
    check("R2 not empty", empty, 0);
    drain_byte(1'b1);
    drain_byte(1'b1);
    drain_byte(1'b1);
    check("R2 empty after drain", empty, 1);

    // R9 session start clears count
    sess_start = 1'b1;
    @(negedge clk);
    sess_start = 1'b0;
    exp_cnt = 0;
    check("R9 count cleared", sent_cnt, 0);

    // R2, R3 fill and overflow
    for (int k = 0; k < 16; k++) drive_byte(8'(k * 17 + 1));
    check("R2 full at 16", full, 1);
    check("R2 wr_ready low when full", wr_ready, 0);
    check("R2 level 16", level, 16);
    drive_byte(8'hEE);
    check("R3 level unchanged after drop", level, 16);
    check("R3 overflow set", overflow, 1);
    for (int k = 0; k < 16; k++) drain_byte(1'b0);
    check("R3 dropped byte never queued", empty, 1);
    check("R8 count after 16", sent_cnt, 16);

    // R7 underrun
    bit_req = 1'b1;
    @(negedge clk);
    bit_req = 1'b0;
    check("R7 sda idle high", sda_out, 1);
    check("R7 underrun set", underrun, 1);
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
    check("R8 empty byte_done no count", sent_cnt, 16);
    check("R7 underrun sticky", underrun, 1);
    sess_start = 1'b1;
    @(negedge clk);
    sess_start = 1'b0;
    exp_cnt = 0;
    check("R9 underrun cleared", underrun, 0);

    // R6 write and removal in the same cycle
    drive_byte(8'h11);
    for (int i = 0; i < 8; i++) begin
      bit_req = 1'b1;
      @(negedge clk);
      bit_req = 1'b0;
      got[7-i] = sda_out;
    end
    check("R4 first byte", got, 8'h11);
    void'(sb_q.pop_front());
    wr_valid = 1'b1;
    wr_data = 8'h22;
    byte_done = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    byte_done = 1'b0;
    sb_q.push_back(8'h22);
    exp_cnt = 1;
    check("R6 level held", level, 1);
    check("R8 count one", sent_cnt, 1);
    drain_byte(1'b1);

    // R9 session start together with a removal
    drive_byte(8'h33);
    sess_start = 1'b1;
    byte_done = 1'b1;
    @(negedge clk);
    sess_start = 1'b0;
    byte_done = 1'b0;
    void'(sb_q.pop_front());
    exp_lvl--;
    exp_cnt = 0;
    check("R9 count zero with pop", sent_cnt, 0);
    check("R9 byte still removed", level, 0);

    // R8 wrap past 127
    for (int k = 0; k < 130; k++) begin
      drive_byte(8'(k ^ 8'h5A));
      drain_byte(1'b0);
      if (k == 127) check("R8 wrap to 0", sent_cnt, 0);
    end
    check("R8 count after wrap", sent_cnt, 2);
    check("R3 overflow still sticky", overflow, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule